// File: doc/BRIEF.md
# Amplifier Protection and Output Sequencer

This block is the synchronous supervisor of a six-channel power output stage. It decides, every clock, which outputs may drive: one bias-precharge output and six audio half-bridge channels, A to F. A disabled output is meant to be held at high impedance by the gate-drive logic that follows. The block's inputs are asynchronous. Two of them come from temperature comparators: a warning level and a shutdown level. The others are one undervoltage flag per monitored supply, a power-on flag, an overload detect, a mode-select pin and an active-low stage-reset pin. It drives an active-low overtemperature warning and an active-low fault flag.

Faults always take priority over the start-up table. Thermal shutdown clears itself after a programmable hold-off once the shutdown flag has gone away. Undervoltage releases the outputs as soon as every supply is back. An overload stays latched until the stage-reset pin rises or until power-on reset. With no fault present, the two pins select among four states: everything off, bias precharge only, the reduced three-channel set, and the full six-channel set.

Top module: `amp_guard`

## Requirements
- R1: `warn_n_o` is low exactly while the synchronized warning flag is high. The warning alone leaves every enable and `fault_n_o` unchanged.
- R2: While the synchronized shutdown flag is high, `bias_en_o` and all of `chan_en_o` are 0. `fault_n_o` is low if the stage-reset pin is high.
- R3: After the shutdown flag falls, the outputs stay disabled for HYST_CYCLES further clock edges. On the next edge they are released, provided the flag stayed low throughout.
- R4: Any bit of `uv_i` disables all outputs and pulls `fault_n_o` low. When every bit is clear again, the outputs return with no other action.
- R5: While `por_i` is high, all outputs are disabled and `fault_n_o` is low (when the stage-reset pin is high). Power-on reset also clears a latched overload. The power-on flag reads as asserted from block reset until it has been synchronized.
- R6: While `stage_rst_n_i` is low, every channel enable is 0 and `fault_n_o` is held high whatever faults exist.
- R7: A high sample of `ovl_i` latches an overload that disables all outputs. The latch survives `ovl_i` returning low and is cleared only by a rising edge of the synchronized `stage_rst_n_i`, or by power-on reset.
- R8: With no fault and `stage_rst_n_i` low: if `mode_sel_i` is 0, every output is off; if it is 1, only `bias_en_o` is 1.
- R9: With no fault and `stage_rst_n_i` high, `bias_en_o` is 0. `mode_sel_i`=1 sets `chan_en_o` all ones. `mode_sel_i`=0 sets only bits 0 to 2 (channels A, B, C; bit n is channel n counting from A).
- R10: Every asynchronous input passes through a two-flop synchronizer. A change applied between edges shows at the outputs right after the second following rising edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| temp_warn_i | input | 1 | Warning-level temperature comparator flag (async) |
| temp_trip_i | input | 1 | Shutdown-level temperature comparator flag (async) |
| uv_i | input | NUM_SUP | One undervoltage flag per supply (async) |
| por_i | input | 1 | Power-on reset active, supplies not yet valid (async) |
| ovl_i | input | 1 | Overload detect (async) |
| mode_sel_i | input | 1 | Mode-select pin (async) |
| stage_rst_n_i | input | 1 | Active-low stage reset pin (async) |
| bias_en_o | output | 1 | Bias-precharge output enable |
| chan_en_o | output | NUM_CH | Half-bridge enables, bit 0 = channel A |
| warn_n_o | output | 1 | Active-low overtemperature warning |
| fault_n_o | output | 1 | Active-low shutdown/fault flag |

## Verification
Outputs are decoded combinationally from synchronized inputs and two pieces of state. A corrupted state therefore shows on the enables on the very cycle it goes wrong. A stuck overload latch keeps every enable at 0 after a stage-reset rising edge that should have released it. A miscounted thermal hold-off releases the channels one or more edges early or late, measured from the second edge after the shutdown flag falls. A synchronizer of the wrong depth moves every response by a whole cycle. The bench catches each of these at the first negative edge after the bad edge, by comparing against a cycle-exact model.

// File: rtl/agd_pkg.sv
package agd_pkg;

   // Start-up table state chosen by the mode-select and stage-reset pins
   typedef enum logic [1:0] {
      STG_OFF      = 2'd0,
      STG_PRECHG   = 2'd1,
      STG_REDUCED  = 2'd2,
      STG_FULL     = 2'd3
   } stage_e;

   function automatic stage_e stage_decode(input logic mode_sel, input logic stage_run);
      stage_e s;
      if (!stage_run) s = mode_sel ? STG_PRECHG : STG_OFF;
      else            s = mode_sel ? STG_FULL   : STG_REDUCED;
      return s;
   endfunction

endpackage

// File: rtl/agd_sync.sv
module agd_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("agd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= RST_VAL;
               else        pipe[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[k] <= RST_VAL;
               else        pipe[k] <= pipe[k-1];
            end
         end
      end
   endgenerate

   assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/agd_fault.sv
module agd_fault #(
   parameter int HYST_CYCLES = 16,
   localparam int CW = $clog2(HYST_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_s,
   input  logic ovl_s,
   input  logic por_s,
   input  logic stage_run_s,
   output logic therm_shut_o,
   output logic ovl_held_o
);

   generate
      if (HYST_CYCLES < 1) begin : g_bad_hyst
         $error("agd_fault: HYST_CYCLES must be at least 1");
      end
   endgenerate

   localparam logic [CW-1:0] HOLD_LAST = CW'(HYST_CYCLES - 1);

   logic          ts_q;
   logic [CW-1:0] cool_cnt;
   logic          run_prev;
   logic          run_rise;

   // Thermal shutdown with cool-down hold-off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_q     <= 1'b0;
         cool_cnt <= '0;
      end else if (trip_s) begin
         ts_q     <= 1'b1;
         cool_cnt <= '0;
      end else if (ts_q) begin
         if (cool_cnt == HOLD_LAST) begin
            ts_q     <= 1'b0;
            cool_cnt <= '0;
         end else begin
            cool_cnt <= cool_cnt + 1'b1;
         end
      end
   end

   assign therm_shut_o = trip_s | ts_q;

   // Stage-reset rising edge on the synchronized pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_prev <= 1'b0;
      else        run_prev <= stage_run_s;
   end

   assign run_rise = stage_run_s & ~run_prev;

   // Overload latch: cleared by power-on or a stage-reset rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovl_held_o <= 1'b0;
      else if (por_s || run_rise)  ovl_held_o <= 1'b0;
      else if (ovl_s)              ovl_held_o <= 1'b1;
   end

endmodule

// File: rtl/agd_map.sv
module agd_map
   import agd_pkg::*;
#(
   parameter int NUM_CH  = 6,
   parameter int RED_CH  = 3
) (
   input  logic              mode_s,
   input  logic              stage_run_s,
   input  logic              fault_i,
   output logic              bias_en_o,
   output logic [NUM_CH-1:0] chan_en_o
);

   generate
      if (RED_CH < 1 || RED_CH >= NUM_CH) begin : g_bad_split
         $error("agd_map: RED_CH must lie between 1 and NUM_CH-1");
      end
   endgenerate

   stage_e stage;

   always_comb stage = stage_decode(mode_s, stage_run_s);

   assign bias_en_o = (stage == STG_PRECHG) & ~fault_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         if (c < RED_CH) begin : g_core
            assign chan_en_o[c] = ((stage == STG_FULL) | (stage == STG_REDUCED)) & ~fault_i;
         end else begin : g_ext
            assign chan_en_o[c] = (stage == STG_FULL) & ~fault_i;
         end
      end
   endgenerate

endmodule

// File: rtl/amp_guard.sv
module amp_guard #(
   parameter int NUM_SUP     = 4,
   parameter int NUM_CH      = 6,
   parameter int RED_CH      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int HYST_CYCLES = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               temp_warn_i,
   input  logic               temp_trip_i,
   input  logic [NUM_SUP-1:0] uv_i,
   input  logic               por_i,
   input  logic               ovl_i,
   input  logic               mode_sel_i,
   input  logic               stage_rst_n_i,
   output logic               bias_en_o,
   output logic [NUM_CH-1:0]  chan_en_o,
   output logic               warn_n_o,
   output logic               fault_n_o
);

   localparam int SW = NUM_SUP + 5;

   generate
      if (NUM_SUP < 1) begin : g_bad_sup
         $error("amp_guard: NUM_SUP must be at least 1");
      end
   endgenerate

   logic [SW-1:0]      raw_bus;
   logic [SW-1:0]      sync_bus;
   logic               warn_s;
   logic               trip_s;
   logic               ovl_s;
   logic               mode_s;
   logic               stage_run_s;
   logic [NUM_SUP-1:0] uv_s;
   logic               por_s;
   logic               therm_shut;
   logic               ovl_held;
   logic               fault_any;

   assign raw_bus = {uv_i, stage_rst_n_i, mode_sel_i, ovl_i, temp_trip_i, temp_warn_i};

   agd_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_main (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_bus),
      .q_o   (sync_bus)
   );

   agd_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_por (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (por_i),
      .q_o   (por_s)
   );

   assign warn_s      = sync_bus[0];
   assign trip_s      = sync_bus[1];
   assign ovl_s       = sync_bus[2];
   assign mode_s      = sync_bus[3];
   assign stage_run_s = sync_bus[4];
   assign uv_s        = sync_bus[SW-1:5];

   agd_fault #(.HYST_CYCLES(HYST_CYCLES)) i_fault (
      .clk          (clk),
      .rst_n        (rst_n),
      .trip_s       (trip_s),
      .ovl_s        (ovl_s),
      .por_s        (por_s),
      .stage_run_s  (stage_run_s),
      .therm_shut_o (therm_shut),
      .ovl_held_o   (ovl_held)
   );

   assign fault_any = therm_shut | (|uv_s) | por_s | ovl_held;

   agd_map #(.NUM_CH(NUM_CH), .RED_CH(RED_CH)) i_map (
      .mode_s      (mode_s),
      .stage_run_s (stage_run_s),
      .fault_i     (fault_any),
      .bias_en_o   (bias_en_o),
      .chan_en_o   (chan_en_o)
   );

   assign warn_n_o  = ~warn_s;
   assign fault_n_o = ~(fault_any & stage_run_s);

endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk #(
   parameter int NUM_SUP = 4,
   parameter int NUM_CH  = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               temp_warn_i,
   input logic               trip_s,
   input logic [NUM_SUP-1:0] uv_s,
   input logic               por_s,
   input logic               mode_s,
   input logic               stage_run_s,
   input logic               ovl_held,
   input logic               bias_en_o,
   input logic [NUM_CH-1:0]  chan_en_o,
   input logic               warn_n_o,
   input logic               fault_n_o
);

   assert_warn_from_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(warn_n_o) |-> $past(temp_warn_i, 2));

   assert_trip_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      trip_s |-> (chan_en_o == '0) && !bias_en_o);

   assert_uv_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|uv_s) |-> (chan_en_o == '0) && !bias_en_o);

   assert_por_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      por_s |=> !ovl_held);

   assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_run_s |-> fault_n_o && (chan_en_o == '0));

   assert_ovl_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_held |-> (chan_en_o == '0) && !bias_en_o);

   assert_off_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stage_run_s && !mode_s) |-> !bias_en_o);

   assert_run_no_bias_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stage_run_s |-> !bias_en_o);

   assert_one_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bias_en_o, |chan_en_o}));

endmodule

bind amp_guard amp_guard_chk #(.NUM_SUP(NUM_SUP), .NUM_CH(NUM_CH)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .temp_warn_i (temp_warn_i),
   .trip_s      (trip_s),
   .uv_s        (uv_s),
   .por_s       (por_s),
   .mode_s      (mode_s),
   .stage_run_s (stage_run_s),
   .ovl_held    (ovl_held),
   .bias_en_o   (bias_en_o),
   .chan_en_o   (chan_en_o),
   .warn_n_o    (warn_n_o),
   .fault_n_o   (fault_n_o)
);

// File: tb/test_amp_guard.sv
`timescale 1ns/1ps
module test_amp_guard;

   localparam int NS   = 4;
   localparam int NC   = 6;
   localparam int HY   = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          warn_i = 0, trip_i = 0, por_i = 1, ovl_i = 0, mode_i = 0, srst_i = 0;
   logic [NS-1:0] uv_i = '0;
   logic          bias_en;
   logic [NC-1:0] chan_en;
   logic          warn_n, fault_n;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #10 clk = ~clk;

   amp_guard #(.NUM_SUP(NS), .NUM_CH(NC), .RED_CH(3), .SYNC_STAGES(2), .HYST_CYCLES(HY)) i_amp_guard (
      .clk(clk), .rst_n(rst_n), .temp_warn_i(warn_i), .temp_trip_i(trip_i), .uv_i(uv_i),
      .por_i(por_i), .ovl_i(ovl_i), .mode_sel_i(mode_i), .stage_rst_n_i(srst_i),
      .bias_en_o(bias_en), .chan_en_o(chan_en), .warn_n_o(warn_n), .fault_n_o(fault_n)
   );

   // Reference model: two-deep delay per input, behavioural fault state
   bit w1, w2, t1, t2, o1, o2, m1, m2, r1, r2, p1, p2, rprev, ovl_lat;
   bit [NS-1:0] u1, u2;
   int cool;   // -1: not in hold-off

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {w1, w2, t1, t2, o1, o2, m1, m2, r1, r2, rprev, ovl_lat} = '0;
         p1 = 1; p2 = 1; u1 = '0; u2 = '0; cool = -1;
      end else begin
         if (p2 || (r2 && !rprev)) ovl_lat = 0;
         else if (o2) ovl_lat = 1;
         if (t2) cool = 0;
         else if (cool >= 0) begin
            cool++;
            if (cool >= HY) cool = -1;
         end
         rprev = r2;
         w2 = w1; t2 = t1; o2 = o1; m2 = m1; r2 = r1; p2 = p1; u2 = u1;
         w1 = warn_i; t1 = trip_i; o1 = ovl_i; m1 = mode_i; r1 = srst_i; p1 = por_i; u1 = uv_i;
      end
   end

   function automatic bit m_fault();
      return t2 || (cool >= 0) || (u2 != 0) || p2 || ovl_lat;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         automatic bit f = m_fault();
         automatic int eb = (!r2 && m2 && !f) ? 1 : 0;
         automatic int ec = (!r2 || f) ? 0 : (m2 ? 'h3F : 'h07);
         chk("R8 model bias", bias_en, eb);
         chk("R9 model chan", chan_en, ec);
         chk("R1 model warn", warn_n, !w2);
         chk("R6 model fault", fault_n, !(f && r2));
      end
   end

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait_n(3);
      rst_n = 1;
      @(negedge clk);
      chk("R5 reset chan", chan_en, 0);
      chk("R5 reset bias", bias_en, 0);
      chk("R6 reset fault_n", fault_n, 1);
      chk("R1 reset warn_n", warn_n, 1);
      por_i = 0; wait_n(4);
      chk("R8 off state", {bias_en, chan_en}, 0);
      mode_i = 1; wait_n(4);
      chk("R8 precharge bias", bias_en, 1);
      chk("R8 precharge chan", chan_en, 0);
      srst_i = 1; wait_n(1);
      chk("R10 one edge unchanged", {bias_en, chan_en}, 'h40);
      wait_n(1);
      chk("R10 two edges changed", {bias_en, chan_en}, 'h3F);
      chk("R9 full set", chan_en, 'h3F);
      mode_i = 0; wait_n(4);
      chk("R9 reduced set", {bias_en, chan_en}, 'h07);
      mode_i = 1; wait_n(4);
      warn_i = 1; wait_n(4);
      chk("R1 warn low", warn_n, 0);
      chk("R1 chans kept", chan_en, 'h3F);
      warn_i = 0;
      trip_i = 1; wait_n(4);
      chk("R2 trip chan", {bias_en, chan_en}, 0);
      chk("R2 trip fault_n", fault_n, 0);
      trip_i = 0; wait_n(1 + HY);
      chk("R3 still held", chan_en, 0);
      wait_n(1);
      chk("R3 released", chan_en, 'h3F);
      uv_i = 4'b0100; wait_n(4);
      chk("R4 uv chan", chan_en, 0);
      chk("R4 uv fault_n", fault_n, 0);
      uv_i = '0; wait_n(4);
      chk("R4 recovered", chan_en, 'h3F);
      ovl_i = 1; wait_n(4);
      chk("R7 ovl chan", chan_en, 0);
      ovl_i = 0; wait_n(4);
      chk("R7 stays latched", chan_en, 0);
      srst_i = 0; wait_n(4);
      chk("R6 fault_n forced high", fault_n, 1);
      chk("R6 chans off", chan_en, 0);
      srst_i = 1; wait_n(4);
      chk("R7 cleared by edge", chan_en, 'h3F);
      ovl_i = 1; wait_n(4); ovl_i = 0;
      por_i = 1; wait_n(4);
      chk("R5 por chan", chan_en, 0);
      chk("R5 por fault_n", fault_n, 0);
      por_i = 0; wait_n(4);
      chk("R5 por cleared ovl", chan_en, 'h3F);
      for (int i = 0; i < 3000; i++) begin
         warn_i = ($urandom_range(0, 3) == 0);
         trip_i = ($urandom_range(0, 11) == 0);
         ovl_i  = ($urandom_range(0, 19) == 0);
         por_i  = ($urandom_range(0, 29) == 0);
         uv_i   = ($urandom_range(0, 9) == 0) ? NS'($urandom) : '0;
         if ($urandom_range(0, 5) == 0) mode_i = ~mode_i;
         if ($urandom_range(0, 7) == 0) srst_i = ~srst_i;
         wait_n(1);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule